// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked single-port memory of 32-bit words, organised as four byte lanes, behind a burst-SRAM style control interface. Every rising clock edge is sorted into one of a few cycle kinds: idle, deselect, burst start, burst advance, burst hold, or sleep. The sorting uses three chip enables, a processor-side and a controller-side address strobe, an advance input, a global write input, a byte-write enable with four per-lane enables, and a sleep input. A burst covers four words that share the upper address bits. The two low address bits step in either an exclusive-or (interleaved) order or a wrapping linear order, picked by a mode input.

Read data is registered: a word addressed on one edge shows up on the output bus during the following cycle. The output-enable input gates the bus combinationally and is never sampled. A wake-up monitor raises a flag when an access is attempted too soon after sleep ends, and it blocks that access.

Top module: `burst_sram_core`

## Requirements
- R1: A cycle where memStrobeN is low, or cpuStrobeN and enPrimN are both low, while the chip is not selected (selected means enPrimN low, enHigh high and enAuxN low) is a deselect. It does no memory access, busDrive is low in the next cycle, and it ends any burst, so a later advance does nothing.
- R2: cpuStrobeN low together with enPrimN low, on a selected chip, always starts a read at addrIn. The write inputs are ignored and memory is left unchanged. cpuStrobeN is ignored while enPrimN is high.
- R3: With cpuStrobeN high, memStrobeN low, the chip selected and the write decode active, the edge writes dataIn to addrIn and starts a write burst there. With the write decode inactive, the same cycle starts a read at addrIn.
- R4: The write decode is active when allWriteN is low, or when byteWriteN is low and at least one bit of laneSelN is low. Otherwise it is inactive.
- R5: When allWriteN is low, all four lanes are written. Otherwise lane k (dataIn bits 8k+7..8k) is written only when laneSelN[k] is low.
- R6: A burst step (both strobes high, advanceN low, burst active) moves to the next of four addresses. Bits above bit 1 stay fixed. The two low bits are start XOR step when linearOrder is 0, and (start + step) mod 4 when linearOrder is 1. The step counts 1, 2, 3 and then wraps to 0.
- R7: During an active burst, a cycle with both strobes high and advanceN high repeats the current address. Each burst step and each hold is a write when the write decode is active and a read otherwise.
- R8: A read on one edge puts the word on dataOut with busDrive high in the next cycle, but only while outEnN is low. busDrive is low in any cycle decoded as a write.
- R9: While sleepIn is high, busDrive is low, all accesses are ignored and any burst is cancelled.
- R10: For the two clock edges after sleepIn falls, accesses are ignored. Any of these makes wakeFault high in the following cycle: the chip is selected, cpuStrobeN is low, or memStrobeN is low.
- R11: After reset, busDrive and wakeFault are low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enPrimN | input | 1 | Primary chip enable, active low, also gates cpuStrobeN |
| enHigh | input | 1 | Chip enable, active high |
| enAuxN | input | 1 | Auxiliary chip enable, active low |
| cpuStrobeN | input | 1 | Processor-side address strobe, active low, always starts a read |
| memStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| allWriteN | input | 1 | Global write of all lanes, active low |
| byteWriteN | input | 1 | Byte-write enable, active low |
| laneSelN | input | 4 | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepIn | input | 1 | Power-down request, active high |
| linearOrder | input | 1 | Burst order: 0 interleaved, 1 linear |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Read data |
| busDrive | output | 1 | Output bus drive enable |
| wakeFault | output | 1 | Access attempted during wake-up recovery |

## Verification
A burst counter or base address that has gone wrong shows up on dataOut one cycle after the first faulty step, as a word from the wrong slot in the four-word group. A burst flag left set after a deselect or after sleep shows up as a stray busDrive on the next advance. A wrong recovery count shows up either as wakeFault in the wrong cycle or as an access that takes effect too early. A corrupted lane store is invisible until that word is read back, so the random phase reads back frequently over a small address space.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int BURST_LEN = 4;
  localparam int STEP_W = $clog2(BURST_LEN);

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_START,
    CYC_STEP,
    CYC_HOLD
  } cycKind_e;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [LANES-1:0] laneWr;
    logic             busOff;
  } memCmd_t;

  function automatic logic [STEP_W-1:0] burstOffset(
    input logic [STEP_W-1:0] startLo,
    input logic [STEP_W-1:0] step,
    input logic              linear
  );
    return linear ? (startLo + step) : (startLo ^ step);
  endfunction
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPrimN,
  input  logic              enHigh,
  input  logic              enAuxN,
  input  logic              cpuStrobeN,
  input  logic              memStrobeN,
  input  logic              advanceN,
  input  logic              allWriteN,
  input  logic              byteWriteN,
  input  logic [LANES-1:0]  laneSelN,
  input  logic              sleepIn,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] addrIn,
  output memCmd_t           cmd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              wakeFault
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic              burstAct;
  logic [ADDR_W-1:0] baseAddr;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] nextStep;
  logic [CNT_W-1:0]  wakeCnt;
  logic              faultQ;

  logic     selected, cpuStart, memStart, writeReq, recovering, blocked;
  logic     isWrite, access;
  cycKind_e kind;

  always_comb begin
    selected   = !enPrimN && enHigh && !enAuxN;
    cpuStart   = !cpuStrobeN && !enPrimN;
    memStart   = !memStrobeN;
    writeReq   = !allWriteN || (!byteWriteN && (laneSelN != '1));
    recovering = (wakeCnt != '0);
    blocked    = sleepIn || recovering;
    nextStep   = stepCnt + 1'b1;
  end

  always_comb begin
    kind    = CYC_IDLE;
    isWrite = 1'b0;
    if (!blocked) begin
      if ((cpuStart || memStart) && !selected) begin
        kind = CYC_DESEL;
      end else if (cpuStart) begin
        kind = CYC_START;
      end else if (memStart) begin
        kind    = CYC_START;
        isWrite = writeReq;
      end else if (burstAct && !advanceN) begin
        kind    = CYC_STEP;
        isWrite = writeReq;
      end else if (burstAct) begin
        kind    = CYC_HOLD;
        isWrite = writeReq;
      end
    end
  end

  always_comb begin
    case (kind)
      CYC_START: memAddr = addrIn;
      CYC_STEP:  memAddr = {baseAddr[ADDR_W-1:STEP_W],
                            burstOffset(baseAddr[STEP_W-1:0], nextStep, linearOrder)};
      default:   memAddr = {baseAddr[ADDR_W-1:STEP_W],
                            burstOffset(baseAddr[STEP_W-1:0], stepCnt, linearOrder)};
    endcase
    access     = (kind == CYC_START) || (kind == CYC_STEP) || (kind == CYC_HOLD);
    cmd.rdEn   = access && !isWrite;
    cmd.wrEn   = access && isWrite;
    cmd.laneWr = !allWriteN ? '1 : (byteWriteN ? '0 : ~laneSelN);
    cmd.busOff = sleepIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstAct <= 1'b0;
      baseAddr <= '0;
      stepCnt  <= '0;
      wakeCnt  <= '0;
      faultQ   <= 1'b0;
    end else begin
      case (kind)
        CYC_START: begin
          baseAddr <= addrIn;
          stepCnt  <= '0;
          burstAct <= 1'b1;
        end
        CYC_STEP:  stepCnt  <= nextStep;
        CYC_DESEL: burstAct <= 1'b0;
        default: ;
      endcase
      if (sleepIn) begin
        burstAct <= 1'b0;
        wakeCnt  <= CNT_W'(WAKE_CYC);
      end else if (recovering) begin
        wakeCnt <= wakeCnt - 1'b1;
      end
      faultQ <= !sleepIn && recovering && (selected || !cpuStrobeN || !memStrobeN);
    end
  end

  assign wakeFault = faultQ;
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memCmd_t           cmd,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              busDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              rdValid;
  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (cmd.wrEn && cmd.laneWr[g]) store[memAddr] <= dataIn[g*LANE_W +: LANE_W];
      if (cmd.rdEn) laneQ <= store[memAddr];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= cmd.rdEn;
  end

  assign busDrive = rdValid && !outEnN && !cmd.busOff && !cmd.wrEn;
  assign dataOut  = rdWord;
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPrimN,
  input  logic              enHigh,
  input  logic              enAuxN,
  input  logic              cpuStrobeN,
  input  logic              memStrobeN,
  input  logic              advanceN,
  input  logic              allWriteN,
  input  logic              byteWriteN,
  input  logic [3:0]        laneSelN,
  input  logic              outEnN,
  input  logic              sleepIn,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [31:0]       dataIn,
  output logic [31:0]       dataOut,
  output logic              busDrive,
  output logic              wakeFault
);
  memCmd_t           cmd;
  logic [ADDR_W-1:0] memAddr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .enPrimN(enPrimN), .enHigh(enHigh), .enAuxN(enAuxN),
    .cpuStrobeN(cpuStrobeN), .memStrobeN(memStrobeN), .advanceN(advanceN),
    .allWriteN(allWriteN), .byteWriteN(byteWriteN), .laneSelN(laneSelN),
    .sleepIn(sleepIn), .linearOrder(linearOrder), .addrIn(addrIn),
    .cmd(cmd), .memAddr(memAddr), .wakeFault(wakeFault)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memAddr(memAddr),
    .dataIn(dataIn), .outEnN(outEnN), .dataOut(dataOut), .busDrive(busDrive)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int WAKE_CYC = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       enPrimN,
  input logic       enHigh,
  input logic       enAuxN,
  input logic       cpuStrobeN,
  input logic       memStrobeN,
  input logic       allWriteN,
  input logic       byteWriteN,
  input logic [3:0] laneSelN,
  input logic       outEnN,
  input logic       sleepIn,
  input logic       busDrive,
  input logic       wakeFault
);
  logic sel, wrDecode;
  int   recC;

  assign sel      = !enPrimN && enHigh && !enAuxN;
  assign wrDecode = !allWriteN || (!byteWriteN && (laneSelN != 4'hF));

  always_ff @(posedge clk) begin
    if (!rstN)        recC <= 0;
    else if (sleepIn) recC <= WAKE_CYC;
    else if (recC != 0) recC <= recC - 1;
  end

  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!memStrobeN && !sel) |=> !busDrive);

  a_r8_oe_gates_bus: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !busDrive);

  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> !busDrive);

  a_r8_write_masks_bus: assert property (@(posedge clk) disable iff (!rstN)
    (recC == 0 && !sleepIn && sel && cpuStrobeN && !memStrobeN && wrDecode) |-> !busDrive);

  a_r10_early_access_flag: assert property (@(posedge clk) disable iff (!rstN)
    (recC != 0 && !sleepIn && (sel || !cpuStrobeN || !memStrobeN)) |=> wakeFault);

  a_r10_flag_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    wakeFault |-> $past(recC != 0));
endmodule

bind burst_sram_core burst_sram_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .enPrimN(enPrimN), .enHigh(enHigh), .enAuxN(enAuxN),
  .cpuStrobeN(cpuStrobeN), .memStrobeN(memStrobeN), .allWriteN(allWriteN),
  .byteWriteN(byteWriteN), .laneSelN(laneSelN), .outEnN(outEnN),
  .sleepIn(sleepIn), .busDrive(busDrive), .wakeFault(wakeFault)
);

// File: tb/burst_sram_core_bench.sv
`timescale 1ns/1ps
module burst_sram_core_bench;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN;
  logic enPrimN, enHigh, enAuxN, cpuStrobeN, memStrobeN, advanceN;
  logic allWriteN, byteWriteN, outEnN, sleepIn, linearOrder;
  logic [3:0] laneSelN;
  logic [ADDR_W-1:0] addrIn;
  logic [31:0] dataIn, dataOut;
  logic busDrive, wakeFault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] mMem [DEPTH];
  logic        mBurst, mRdValid, mFault;
  logic [ADDR_W-1:0] mBase;
  logic [1:0]  mStep;
  int          mWake;
  logic [31:0] mRdWord;

  always #10 clk = ~clk;

  burst_sram_core #(.ADDR_W(ADDR_W), .WAKE_CYC(2)) u_burst_sram_core (
    .clk(clk), .rstN(rstN), .enPrimN(enPrimN), .enHigh(enHigh), .enAuxN(enAuxN),
    .cpuStrobeN(cpuStrobeN), .memStrobeN(memStrobeN), .advanceN(advanceN),
    .allWriteN(allWriteN), .byteWriteN(byteWriteN), .laneSelN(laneSelN),
    .outEnN(outEnN), .sleepIn(sleepIn), .linearOrder(linearOrder),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut),
    .busDrive(busDrive), .wakeFault(wakeFault)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] offs(input logic [1:0] lo, input logic [1:0] st, input logic lin);
    return lin ? lo + st : lo ^ st;
  endfunction

  task automatic setIdle();
    enPrimN = 1; enHigh = 0; enAuxN = 1; cpuStrobeN = 1; memStrobeN = 1;
    advanceN = 1; allWriteN = 1; byteWriteN = 1; laneSelN = 4'hF;
    outEnN = 0; sleepIn = 0;
  endtask

  task automatic selectChip();
    enPrimN = 0; enHigh = 1; enAuxN = 0;
  endtask

  // One clock: check outputs against the model, then advance the model past the edge.
  task automatic runCycle(input string tag);
    logic sel, cpuSt, memSt, wrReq, blocked, acc, isWr, expDrive, fNext;
    logic [ADDR_W-1:0] a;
    logic [3:0] mask;
    int kind;
    #2;
    sel   = !enPrimN && enHigh && !enAuxN;
    cpuSt = !cpuStrobeN && !enPrimN;
    memSt = !memStrobeN;
    wrReq = !allWriteN || (!byteWriteN && laneSelN != 4'hF);
    blocked = sleepIn || (mWake != 0);
    kind = 0; isWr = 0;
    if (!blocked) begin
      if ((cpuSt || memSt) && !sel) kind = 1;
      else if (cpuSt) kind = 2;
      else if (memSt) begin kind = 2; isWr = wrReq; end
      else if (mBurst && !advanceN) begin kind = 3; isWr = wrReq; end
      else if (mBurst) begin kind = 4; isWr = wrReq; end
    end
    acc = (kind >= 2);
    if (kind == 2)      a = addrIn;
    else if (kind == 3) a = {mBase[ADDR_W-1:2], offs(mBase[1:0], mStep + 2'd1, linearOrder)};
    else                a = {mBase[ADDR_W-1:2], offs(mBase[1:0], mStep, linearOrder)};
    mask = !allWriteN ? 4'hF : (byteWriteN ? 4'h0 : ~laneSelN);
    expDrive = mRdValid && !outEnN && !sleepIn && !(acc && isWr);
    check(busDrive === expDrive, tag, "busDrive", 32'(busDrive), 32'(expDrive));
    if (expDrive && busDrive)
      check(dataOut === mRdWord, tag, "dataOut", dataOut, mRdWord);
    check(wakeFault === mFault, tag, "wakeFault", 32'(wakeFault), 32'(mFault));
    fNext = !sleepIn && (mWake != 0) && (sel || !cpuStrobeN || !memStrobeN);
    @(posedge clk);
    #1;
    mRdValid = acc && !isWr;
    if (acc && !isWr) mRdWord = mMem[a];
    if (acc && isWr)
      for (int l = 0; l < 4; l++)
        if (mask[l]) mMem[a][l*8 +: 8] = dataIn[l*8 +: 8];
    if (kind == 2) begin mBase = addrIn; mStep = 0; mBurst = 1; end
    else if (kind == 3) mStep = mStep + 2'd1;
    else if (kind == 1) mBurst = 0;
    if (sleepIn) begin mBurst = 0; mWake = 2; end
    else if (mWake != 0) mWake--;
    mFault = fNext;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
    setIdle(); selectChip(); memStrobeN = 0; allWriteN = 0; addrIn = a; dataIn = d;
    runCycle(tag);
    setIdle();
  endtask

  task automatic readWord(input logic [ADDR_W-1:0] a, input string tag);
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = a;
    runCycle(tag);
    setIdle();
    runCycle(tag);
  endtask

  task automatic randomCycle();
    int r;
    sleepIn = ($urandom % 64) == 0;
    r = $urandom % 8;
    if (r < 6) selectChip();
    else begin enPrimN = 1'($urandom); enHigh = 1'($urandom); enAuxN = 1'($urandom); end
    cpuStrobeN  = ($urandom % 5) != 0;
    memStrobeN  = ($urandom % 4) != 0;
    advanceN    = ($urandom % 2) != 0;
    allWriteN   = ($urandom % 4) != 0;
    byteWriteN  = ($urandom % 2) != 0;
    laneSelN    = 4'($urandom);
    outEnN      = ($urandom % 4) == 0;
    linearOrder = 1'($urandom);
    addrIn      = ADDR_W'($urandom);
    dataIn      = $urandom;
    runCycle("RND");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    mBurst = 0; mRdValid = 0; mFault = 0; mBase = '0; mStep = 0; mWake = 0; mRdWord = '0;
    setIdle(); linearOrder = 0; addrIn = '0; dataIn = '0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11: reset state
    #2;
    check(busDrive === 1'b0, "R11", "busDrive", 32'(busDrive), 32'h0);
    check(wakeFault === 1'b0, "R11", "wakeFault", 32'(wakeFault), 32'h0);
    runCycle("R11");

    // R3: fill every word through the controller-side strobe
    for (int a = 0; a < DEPTH; a++)
      writeWord(ADDR_W'(a), 32'h5A3C9600 ^ (32'(a) * 32'h01010101), "R3");
    readWord(4'd7, "R3");
    readWord(4'd12, "R3");

    // R2: processor strobe with every write input active still reads
    setIdle(); selectChip(); cpuStrobeN = 0; allWriteN = 0; byteWriteN = 0;
    laneSelN = 4'h0; addrIn = 4'd3; dataIn = 32'hDEADBEEF;
    runCycle("R2");
    setIdle(); runCycle("R2");
    readWord(4'd3, "R2");
    // R2: processor strobe ignored while enPrimN high
    setIdle(); enHigh = 1; enAuxN = 0; cpuStrobeN = 0; addrIn = 4'd4;
    runCycle("R2"); setIdle(); runCycle("R2");

    // R4: byte-write enable low but no lane selected -> read, not write
    setIdle(); selectChip(); memStrobeN = 0; byteWriteN = 0; laneSelN = 4'hF;
    addrIn = 4'd2; dataIn = 32'h11111111;
    runCycle("R4"); setIdle(); runCycle("R4");
    // R4: lanes low but byte-write enable high -> read
    setIdle(); selectChip(); memStrobeN = 0; laneSelN = 4'h0; addrIn = 4'd2;
    runCycle("R4"); setIdle(); runCycle("R4");
    readWord(4'd2, "R4");

    // R5: only lane 2 written
    setIdle(); selectChip(); memStrobeN = 0; byteWriteN = 0; laneSelN = 4'b1011;
    addrIn = 4'd9; dataIn = 32'hA1B2C3D4;
    runCycle("R5"); setIdle();
    readWord(4'd9, "R5");

    // R6: interleaved burst from 5, then linear burst from 6
    linearOrder = 0;
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd5; runCycle("R6");
    for (int s = 0; s < 4; s++) begin setIdle(); linearOrder = 0; advanceN = 0; runCycle("R6"); end
    setIdle(); runCycle("R6");
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd6; linearOrder = 1; runCycle("R6");
    for (int s = 0; s < 4; s++) begin setIdle(); linearOrder = 1; advanceN = 0; runCycle("R6"); end
    // R6/R7: burst write steps
    setIdle(); selectChip(); memStrobeN = 0; allWriteN = 0; addrIn = 4'd13; dataIn = 32'h0BADF00D;
    linearOrder = 1; runCycle("R6");
    setIdle(); linearOrder = 1; advanceN = 0; allWriteN = 0; dataIn = 32'h12345678; runCycle("R7");
    setIdle(); linearOrder = 1; runCycle("R7");
    readWord(4'd14, "R6");

    // R7: hold repeats the current address
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd10; linearOrder = 0; runCycle("R7");
    setIdle(); runCycle("R7"); runCycle("R7");

    // R8: output enable high blocks the bus; write cycle masks it
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd1; runCycle("R8");
    setIdle(); outEnN = 1; runCycle("R8");
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd1; runCycle("R8");
    setIdle(); selectChip(); memStrobeN = 0; allWriteN = 0; addrIn = 4'd0; dataIn = 32'hCAFE0001;
    runCycle("R8");
    setIdle(); runCycle("R8");

    // R1: deselect ends the burst; later advance does nothing
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd8; runCycle("R1");
    setIdle(); memStrobeN = 0; enPrimN = 0; enHigh = 0; enAuxN = 0; runCycle("R1");
    setIdle(); advanceN = 0; runCycle("R1"); runCycle("R1");

    // R9: sleep blocks a pending read and a write attempt
    setIdle(); selectChip(); cpuStrobeN = 0; addrIn = 4'd11; runCycle("R9");
    setIdle(); sleepIn = 1; runCycle("R9");
    setIdle(); sleepIn = 1; selectChip(); memStrobeN = 0; allWriteN = 0; addrIn = 4'd11;
    dataIn = 32'hFFFF0000; runCycle("R9");
    // R10: early access after wake is flagged and ignored
    setIdle(); selectChip(); memStrobeN = 0; allWriteN = 0; addrIn = 4'd11; dataIn = 32'h77777777;
    runCycle("R10");
    setIdle(); cpuStrobeN = 0; runCycle("R10");
    setIdle(); runCycle("R10");
    readWord(4'd11, "R9");
    // R10: quiet recovery raises no flag
    setIdle(); sleepIn = 1; runCycle("R10");
    setIdle(); runCycle("R10"); runCycle("R10"); runCycle("R10");

    for (int i = 0; i < 4000; i++) randomCycle();
    setIdle(); runCycle("RND"); runCycle("RND"); runCycle("RND");
    for (int a = 0; a < DEPTH; a++) readWord(ADDR_W'(a), "R5");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule